// File: doc/BRIEF.md
# Instruction Word Holding Register

This block sits between an instruction cache (or a plain memory port) and a decode stage. The decode stage takes one 16-bit instruction word for each request. The block keeps one aligned 32-bit longword, which holds two instruction words. It hands those words out one at a time and goes back to memory only when the word it needs next is no longer in the register. That happens when both halves have been used, or when a branch has moved the program counter somewhere else.

Every word handed to decode falls into exactly one of three classes, and each class has its own saturating counter:

- **Hit:** the word came from a refill that the cache reported as a hit.
- **Miss:** the word came from a refill that the cache reported as a miss.
- **Held:** the word was already sitting in the register, so it needed no cache access at all.

When the memory port is configured 16 bits wide, a refill becomes two word accesses instead of one longword access.

Memory traffic uses a request/grant handshake. After the grant, a single response valid comes back carrying the data and a hit flag. Only one access is ever outstanding. A branch that arrives during an access causes the returning data to be thrown away, and the fetch then restarts at the branch target.

Top module: `iword_hold`

## Requirements
- R1: The register holds one aligned longword. The word at the lower address sits in bits 31:16 and the word at the higher address sits in bits 15:0. `word_data` shows the half selected by bit 1 of `word_addr`, and that value equals the memory contents at `word_addr`.
- R2: A delivery occurs on a clock edge where `word_req` and `word_vld` are both high. Delivering the word whose address has bit 1 clear never starts an access. A run of sequential words therefore costs one memory refill per two words.
- R3: After reset the register is empty and no access is made until `word_req` is raised. The first access goes to the longword holding `RESET_PC`.
- R4: `br_en` throws away any held word and loads the program counter from `br_tgt`, ignoring bit 0. In the following cycle it raises `mem_req` for the longword that contains the target. The word delivered from that refill is counted as a hit or a miss.
- R5: When the branch target has address bit 1 set, only the higher-address word of the fetched longword is delivered. The next sequential word causes a new access.
- R6: `mem_req` stays high with a stable `mem_addr` until `mem_gnt`. While a refill is outstanding, `word_vld` stays low.
- R7: With `bus16` high, a refill is two accesses with `mem_long` low. The first access goes to the longword address and the second to that address plus 2. The first returned `mem_rdata[15:0]` fills bits 31:16. The refill counts as a miss if either access returned `mem_hit` low. With `bus16` low, `mem_long` is high and a single access fills all 32 bits.
- R8: If a branch arrives while an access is outstanding, that access's response is discarded. A new access is then made to the branch target, and the discarded data is never delivered or counted.
- R9: Each delivered word increments exactly one counter. The first word delivered after a refill completes increments `cnt_hit` (if `mem_hit` was high) or `cnt_miss`. Any other delivered word increments `cnt_held`.
- R10: The counters saturate at all ones instead of wrapping.
- R11: `clr_stats` zeroes all three counters on the next edge and takes priority over any increment.
- R12: While `br_en` is high, `word_vld` is low, so a branch wins over word delivery in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_stats | input | 1 | Synchronous clear of the three counters |
| bus16 | input | 1 | 1: memory port is 16 bits, refill by two word accesses |
| word_req | input | 1 | Decode stage wants a word |
| word_vld | output | 1 | `word_data` holds the word at `word_addr` |
| word_data | output | 16 | Instruction word |
| word_addr | output | ADDR_W | Byte address of `word_data` |
| br_en | input | 1 | Redirect fetch to `br_tgt` |
| br_tgt | input | ADDR_W | Branch target byte address (bit 0 ignored) |
| mem_req | output | 1 | Access request |
| mem_gnt | input | 1 | Request accepted |
| mem_addr | output | ADDR_W | Access byte address |
| mem_long | output | 1 | 1: longword access, 0: word access |
| mem_rvld | input | 1 | Response valid, one per grant |
| mem_rdata | input | 32 | Response data (word access uses bits 15:0) |
| mem_hit | input | 1 | Response came from the cache |
| cnt_hit | output | CNT_W | Words delivered from refills that hit |
| cnt_miss | output | CNT_W | Words delivered from refills that missed |
| cnt_held | output | CNT_W | Words delivered with no access |

## Verification
The bench's memory model grants immediately and answers one cycle after the grant. A branch therefore raises `mem_req` one edge later, and the first word becomes valid after the response edge. In 16-bit mode the bench allows one extra request/response pair before that word appears. The bench never samples a fixed cycle for data. It drives inputs and reads outputs at the falling edge, and each delivered word is checked in the same low phase in which `word_vld` is seen together with `word_req`. Counter and access-count results come from registers that update on the delivery edge itself. The bench therefore compares them only after the request has been dropped and a further edge has passed, so no in-flight increment can be missed.

// File: rtl/iword_hold.sv
module iword_hold #(
  parameter int ADDR_W = 32,
  parameter int CNT_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_stats,
  input  logic              bus16,
  input  logic              word_req,
  output logic              word_vld,
  output logic [15:0]       word_data,
  output logic [ADDR_W-1:0] word_addr,
  input  logic              br_en,
  input  logic [ADDR_W-1:0] br_tgt,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_long,
  input  logic              mem_rvld,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_hit,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss,
  output logic [CNT_W-1:0]  cnt_held
);

  localparam int SUM_W = CNT_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DRAIN} st_t;

  st_t               st;
  logic [ADDR_W-1:0] pc;
  logic [31:0]       hold;
  logic              hold_vld;
  logic              half;
  logic              acc_miss;
  logic              fresh;
  logic              fresh_miss;
  logic              deliver;
  logic              unused_bit;
  logic [ADDR_W-1:0] tgt_al;
  logic [ADDR_W-1:0] pc_inc;

  assign unused_bit = br_tgt[0];
  assign tgt_al     = {br_tgt[ADDR_W-1:1], 1'b0};
  assign pc_inc     = pc + ADDR_W'(2);

  assign word_vld  = (st == ST_IDLE) && hold_vld && !br_en;
  assign word_data = pc[1] ? hold[15:0] : hold[31:16];
  assign word_addr = pc;
  assign deliver   = word_vld && word_req;

  assign mem_req  = (st == ST_REQ);
  assign mem_addr = {pc[ADDR_W-1:2], half, 1'b0};
  assign mem_long = !bus16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      pc         <= RESET_PC;
      hold       <= '0;
      hold_vld   <= 1'b0;
      half       <= 1'b0;
      acc_miss   <= 1'b0;
      fresh      <= 1'b0;
      fresh_miss <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (br_en) begin
            pc       <= tgt_al;
            hold_vld <= 1'b0;
            fresh    <= 1'b0;
            half     <= 1'b0;
            acc_miss <= 1'b0;
            st       <= ST_REQ;
          end else if (deliver) begin
            pc    <= pc_inc;
            fresh <= 1'b0;
            if (pc[1]) hold_vld <= 1'b0;
          end else if (!hold_vld && word_req) begin
            half     <= 1'b0;
            acc_miss <= 1'b0;
            st       <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (br_en) begin
            pc       <= tgt_al;
            half     <= 1'b0;
            acc_miss <= 1'b0;
            if (mem_gnt) st <= ST_DRAIN;
          end else if (mem_gnt) begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (br_en) begin
            pc       <= tgt_al;
            half     <= 1'b0;
            acc_miss <= 1'b0;
            st       <= mem_rvld ? ST_REQ : ST_DRAIN;
          end else if (mem_rvld) begin
            if (bus16 && !half) begin
              hold[31:16] <= mem_rdata[15:0];
              acc_miss    <= !mem_hit;
              half        <= 1'b1;
              st          <= ST_REQ;
            end else begin
              if (bus16) hold[15:0] <= mem_rdata[15:0];
              else       hold       <= mem_rdata;
              hold_vld   <= 1'b1;
              fresh      <= 1'b1;
              fresh_miss <= acc_miss || !mem_hit;
              half       <= 1'b0;
              st         <= ST_IDLE;
            end
          end
        end
        default: begin
          if (br_en) pc <= tgt_al;
          if (mem_rvld) begin
            half     <= 1'b0;
            acc_miss <= 1'b0;
            st       <= ST_REQ;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_hit  <= '0;
      cnt_miss <= '0;
      cnt_held <= '0;
    end else if (clr_stats) begin
      cnt_hit  <= '0;
      cnt_miss <= '0;
      cnt_held <= '0;
    end else if (deliver) begin
      if (!fresh)          cnt_held <= (&cnt_held) ? cnt_held : cnt_held + 1'b1;
      else if (fresh_miss) cnt_miss <= (&cnt_miss) ? cnt_miss : cnt_miss + 1'b1;
      else                 cnt_hit  <= (&cnt_hit)  ? cnt_hit  : cnt_hit + 1'b1;
    end
  end

  logic [SUM_W-1:0] cnt_sum;
  assign cnt_sum = SUM_W'(cnt_hit) + SUM_W'(cnt_miss) + SUM_W'(cnt_held);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !br_en |=> mem_req && $stable(mem_addr));

  // R6
  no_word_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !word_vld);

  // R9
  one_count_per_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver && !clr_stats && !(&cnt_hit) && !(&cnt_miss) && !(&cnt_held)
    |=> cnt_sum == $past(cnt_sum) + 1'b1);

  // R9
  idle_counts_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver && !clr_stats |=> $stable(cnt_hit) && $stable(cnt_miss) && $stable(cnt_held));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stats |=> cnt_hit == '0 && cnt_miss == '0 && cnt_held == '0);

  // R2
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> word_addr == $past(word_addr) + ADDR_W'(2));

  // R7
  long_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_long |-> mem_addr[1:0] == 2'b00);

  // R12
  branch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_en |-> !word_vld);

endmodule

// File: tb/test_iword_hold.sv
module test_iword_hold;
  localparam int AW = 32;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, clr_stats = 1'b0, bus16 = 1'b0;
  logic word_req = 1'b0, br_en = 1'b0;
  logic [AW-1:0] br_tgt = '0;
  logic word_vld, mem_req, mem_long;
  logic [15:0] word_data;
  logic [AW-1:0] word_addr, mem_addr;
  logic mem_gnt, mem_rvld, mem_hit;
  logic [31:0] mem_rdata;
  logic [CW-1:0] cnt_hit, cnt_miss, cnt_held;

  int errors = 0, checks = 0, cycles = 0, acc_cnt = 0, long_bad = 0;
  logic gnt_en = 1'b1;
  int resp_lat = 0;
  logic pend = 1'b0, plong = 1'b0;
  int lat = 0;
  logic [AW-1:0] paddr = '0;

  always #4 clk = ~clk;

  iword_hold #(.ADDR_W(AW), .CNT_W(CW), .RESET_PC(32'h200)) i_iword_hold (
    .clk, .rst_n, .clr_stats, .bus16, .word_req, .word_vld, .word_data, .word_addr,
    .br_en, .br_tgt, .mem_req, .mem_gnt, .mem_addr, .mem_long, .mem_rvld,
    .mem_rdata, .mem_hit, .cnt_hit, .cnt_miss, .cnt_held);

  function automatic logic [15:0] wv(logic [AW-1:0] a);
    return a[15:0] + 16'h1000;
  endfunction

  assign mem_gnt   = gnt_en;
  assign mem_rvld  = pend && (lat == 0);
  assign mem_rdata = plong ? {wv(paddr), wv(paddr + 2)} : {16'h0, wv(paddr)};
  assign mem_hit   = !paddr[5];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rvld) pend <= 1'b0;
    else if (pend) lat <= lat - 1;
    if (mem_req && mem_gnt) begin
      pend    <= 1'b1;
      lat     <= resp_lat;
      paddr   <= mem_addr;
      plong   <= mem_long;
      acc_cnt <= acc_cnt + 1;
      if (mem_long == bus16) long_bad <= long_bad + 1;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_branch(logic [AW-1:0] t);
    @(negedge clk);
    br_en = 1'b1; br_tgt = t;
    @(negedge clk);
    br_en = 1'b0;
  endtask

  task automatic read_words(int n, logic [AW-1:0] a0, string req);
    int got = 0;
    word_req = 1'b1;
    while (got < n) begin
      @(negedge clk);
      if (word_vld) begin
        chk(word_addr == a0 + AW'(2 * got), req, word_addr, a0 + AW'(2 * got));
        chk(word_data == wv(a0 + AW'(2 * got)), req, {16'h0, word_data}, {16'h0, wv(a0 + AW'(2 * got))});
        got++;
        if (got == n) begin
          @(posedge clk);
          #1 word_req = 1'b0;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic clear_stats();
    @(negedge clk);
    clr_stats = 1'b1;
    @(negedge clk);
    clr_stats = 1'b0;
    // R11
    chk(cnt_hit == 0 && cnt_miss == 0 && cnt_held == 0, "R11 clear",
        {20'h0, cnt_hit, cnt_miss, cnt_held}, 32'h0);
  endtask

  task automatic chk_counts(int h, int m, int d, int acc, int acc0, string req);
    chk(cnt_hit == CW'(h), {req, " hit"}, {28'h0, cnt_hit}, h);
    chk(cnt_miss == CW'(m), {req, " miss"}, {28'h0, cnt_miss}, m);
    chk(cnt_held == CW'(d), {req, " held"}, {28'h0, cnt_held}, d);
    chk(acc_cnt - acc0 == acc, {req, " accesses"}, acc_cnt - acc0, acc);
  endtask

  typedef struct packed {
    logic        b16;
    logic [31:0] tgt;
    logic [7:0]  n, hit, miss, held, acc;
  } vec_t;

  localparam vec_t VECS[4] = '{
    '{1'b0, 32'h100, 8'd8, 8'd4, 8'd0, 8'd4, 8'd4},
    '{1'b0, 32'h122, 8'd5, 8'd0, 8'd3, 8'd2, 8'd3},
    '{1'b1, 32'h01C, 8'd6, 8'd1, 8'd2, 8'd3, 8'd6},
    '{1'b1, 32'h046, 8'd3, 8'd2, 8'd0, 8'd1, 8'd4}
  };

  initial begin
    int a0;
    // R3 reset state
    #2;
    chk(!word_vld && !mem_req, "R3 reset outputs", {word_vld, mem_req}, 0);
    chk(cnt_hit == 0 && cnt_miss == 0 && cnt_held == 0, "R3 reset counters", {cnt_hit, cnt_miss, cnt_held}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_req, "R3 no fetch before request", mem_req, 0);
    // R6 request held without grant
    gnt_en = 1'b0;
    word_req = 1'b1;
    @(negedge clk);
    chk(mem_req && mem_addr == 32'h200, "R3 first fetch at reset pc", mem_addr, 32'h200);
    repeat (2) @(negedge clk);
    chk(mem_req && mem_addr == 32'h200 && !word_vld, "R6 request held", {mem_req, word_vld}, 2);
    gnt_en = 1'b1;
    read_words(1, 32'h200, "R1 first word");
    chk(cnt_hit == 1, "R9 first word hit", cnt_hit, 1);

    // vector table: R1 R2 R4 R5 R7 R9
    for (int v = 0; v < 4; v++) begin
      clear_stats();
      bus16 = VECS[v].b16;
      a0 = acc_cnt;
      do_branch(VECS[v].tgt);
      read_words(int'(VECS[v].n), VECS[v].tgt, "R1 R2 R5 R7 stream");
      repeat (2) @(negedge clk);
      chk_counts(VECS[v].hit, VECS[v].miss, VECS[v].held, VECS[v].acc, a0, "R2 R4 R7 R9 vector");
    end
    chk(long_bad == 0, "R7 access width", long_bad, 0);
    bus16 = 1'b0;

    // R12 branch over held word in same cycle as request; R4 discard
    clear_stats();
    a0 = acc_cnt;
    do_branch(32'h80);
    read_words(1, 32'h80, "R4 branch");
    @(negedge clk);
    word_req = 1'b1; br_en = 1'b1; br_tgt = 32'hA0;
    #1 chk(!word_vld, "R12 branch blocks word", word_vld, 0);
    @(negedge clk);
    br_en = 1'b0;
    read_words(1, 32'hA0, "R4 held word dropped");
    repeat (2) @(negedge clk);
    chk_counts(1, 1, 0, 2, a0, "R4 R12");

    // R8 branch while response outstanding
    clear_stats();
    a0 = acc_cnt;
    resp_lat = 4;
    do_branch(32'h2E0);
    @(negedge clk);
    chk(pend, "R8 access outstanding", pend, 1);
    do_branch(32'h300);
    read_words(1, 32'h300, "R8 restart");
    resp_lat = 0;
    repeat (2) @(negedge clk);
    chk_counts(1, 0, 0, 2, a0, "R8");

    // R10 saturation
    clear_stats();
    a0 = acc_cnt;
    do_branch(32'h600);
    read_words(40, 32'h600, "R10 long run");
    repeat (2) @(negedge clk);
    chk_counts(12, 8, 15, 20, a0, "R10 saturate");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected<50000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule